// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the timing strobes for the external memory bus of a classic 8-bit microcontroller. It runs directly from the oscillator clock. It divides that clock into machine cycles of twelve clocks, made of six states of two clocks each. It drives three outputs:

- an address-latch strobe, which tells external logic to capture the low address byte;
- an active-low program-store read strobe, used on code fetches from external program memory;
- a select that tells the high-address port whether to drive the upper address byte or the contents of its own output latch.

At the start of every machine cycle, the core hands the sequencer a request type and an instruction-class flag. The sequencer holds both for the whole cycle and shapes the strobes from them. A software-controlled disable bit can silence the address-latch strobe. The exception is a cycle flagged as an external-data move or a code-table move: the strobe still runs in that cycle.

Top module: `bus_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clocks, numbered 0 to 11. Reset starts the sequencer at clock 0 of an idle cycle. In idle (request 0) and fetch (request 1) cycles, the latch strobe `ale_o` is high during clocks 0-1 and 6-7 and low otherwise. This gives a pulse every 6 clocks.
- R2: In an external-data cycle (request 2 = 16-bit pointer access, request 3 = 8-bit register-indirect access), the second latch pulse (clocks 6-7) is left out. The first pulse (clocks 0-1) remains.
- R3: The disable bit is loaded from `ale_off_d` on a clock where `ale_off_we` is high, and reset clears it. While the bit is set, `ale_o` stays low for the whole cycle unless the class flag `xmove_i` was 1 at the start of that cycle. In that case `ale_o` follows R1 and R2.
- R4: `psen_n_o` is low during clocks 3-5 and 9-11 of a fetch cycle, and high at every other time.
- R5: `psen_n_o` stays high for all 12 clocks of both kinds of external-data cycle, so both read pulses are omitted.
- R6: `hi_sel_o` is 1 for the whole of a fetch cycle or a 16-bit pointer data cycle, meaning the upper address byte is driven. It is 0 for a register-indirect data cycle or an idle cycle, meaning the port latch is driven.
- R7: `req_i` and `xmove_i` are captured only on the clock edge that ends clock 11. Changing them at any other time has no effect on the cycle in progress.
- R8: While reset is held, `psen_n_o` is high and `hi_sel_o` is 0.
- R9: `ale_o` high and `psen_n_o` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 2 | Request for next cycle: 0 idle, 1 fetch, 2 wide-pointer data, 3 narrow-pointer data |
| xmove_i | input | 1 | Next cycle belongs to an external-data or code-table move |
| ale_off_we | input | 1 | Write enable for the latch-strobe disable bit |
| ale_off_d | input | 1 | Value written to the disable bit |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| hi_sel_o | output | 1 | High port source: 1 upper address, 0 port latch |

## Verification
The embedded properties assume that `req_i` and `xmove_i` only matter at the cycle boundary. They make no assumption about those inputs between boundaries, and take any value of the disable write pair at any clock. The stimulus changes all inputs on falling edges only. It deliberately changes the request and the class flag in the middle of each cycle to show that they are ignored there. It writes the disable bit on the last clock of a cycle, so that each new setting governs a whole cycle.

// File: rtl/bss_pkg.sv
package bss_pkg;

  typedef enum logic [1:0] {
    REQ_IDLE   = 2'd0,
    REQ_FETCH  = 2'd1,
    REQ_XWIDE  = 2'd2,
    REQ_XNARROW = 2'd3
  } bss_req_e;

  // Latch strobe window: the first state of each half machine cycle.
  function automatic logic ale_window(int unsigned pos, int unsigned half,
                                      int unsigned cps);
    return (pos % half) < cps;
  endfunction

  // Read strobe window: the second half of each half machine cycle.
  function automatic logic psen_window(int unsigned pos, int unsigned half);
    return (pos % half) >= (half / 2);
  endfunction

  function automatic logic is_xdata(bss_req_e r);
    return (r == REQ_XWIDE) || (r == REQ_XNARROW);
  endfunction

endpackage

// File: rtl/bss_phase_ctr.sv
module bss_phase_ctr #(
  parameter int unsigned CYC_LEN = 12,
  localparam int unsigned POS_W = $clog2(CYC_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos_o,
  output logic             cyc_end_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CYC_LEN - 1);

  logic [POS_W-1:0] pos_q;

  assign cyc_end_o = (pos_q == LAST);
  assign pos_o     = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= '0;
    else if (cyc_end_o) pos_q <= '0;
    else               pos_q <= pos_q + 1'b1;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == LAST) |=> (pos_q == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != LAST) |=> (pos_q == $past(pos_q) + 1'b1));

endmodule

// File: rtl/bss_cycle_latch.sv
module bss_cycle_latch
  import bss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bss_req_e req_i,
  input  logic     xmove_i,
  input  logic     ale_off_we,
  input  logic     ale_off_d,
  input  logic     cyc_end_i,
  output bss_req_e cur_req_o,
  output logic     cur_xmove_o,
  output logic     ale_off_o
);
  bss_req_e req_q;
  logic     xmove_q;
  logic     off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= REQ_IDLE;
      xmove_q <= 1'b0;
    end else if (cyc_end_i) begin
      req_q   <= req_i;
      xmove_q <= xmove_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          off_q <= 1'b0;
    else if (ale_off_we) off_q <= ale_off_d;
  end

  assign cur_req_o   = req_q;
  assign cur_xmove_o = xmove_q;
  assign ale_off_o   = off_q;

  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end_i |=> ($stable(req_q) && $stable(xmove_q)));
  p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_off_we |=> $stable(off_q));

endmodule

// File: rtl/bss_strobe_gen.sv
module bss_strobe_gen
  import bss_pkg::*;
#(
  parameter int unsigned CYC_LEN = 12,
  parameter int unsigned CLKS_PER_STATE = 2,
  localparam int unsigned POS_W = $clog2(CYC_LEN),
  localparam int unsigned HALF = CYC_LEN / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_i,
  input  bss_req_e         cur_req_i,
  input  logic             cur_xmove_i,
  input  logic             ale_off_i,
  output logic             ale_o,
  output logic             psen_o,
  output logic             hi_sel_o
);
  logic in_ale_win;
  logic in_psen_win;
  logic second_half;
  logic ale_skip;
  logic ale_gate;

  assign in_ale_win  = ale_window(int'(pos_i), HALF, CLKS_PER_STATE);
  assign in_psen_win = psen_window(int'(pos_i), HALF);
  assign second_half = int'(pos_i) >= HALF;
  assign ale_skip    = is_xdata(cur_req_i) && second_half;
  assign ale_gate    = !ale_off_i || cur_xmove_i;

  always_comb begin
    ale_o    = in_ale_win && !ale_skip && ale_gate;
    psen_o   = in_psen_win && (cur_req_i == REQ_FETCH);
    hi_sel_o = (cur_req_i == REQ_FETCH) || (cur_req_i == REQ_XWIDE);
  end

  p_xdata_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_xdata(cur_req_i) && second_half) |-> !ale_o);
  p_ale_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_off_i && !cur_xmove_i) |-> !ale_o);
  p_no_psen_xdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_xdata(cur_req_i) |-> !psen_o);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && psen_o));

endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bss_pkg::*;
#(
  parameter int unsigned STATES = 6,
  parameter int unsigned CLKS_PER_STATE = 2,
  parameter bit PSEN_ACTIVE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       xmove_i,
  input  logic       ale_off_we,
  input  logic       ale_off_d,
  output logic       ale_o,
  output logic       psen_n_o,
  output logic       hi_sel_o
);
  localparam int unsigned CYC_LEN = STATES * CLKS_PER_STATE;
  localparam int unsigned POS_W = $clog2(CYC_LEN);

  logic [POS_W-1:0] pos;
  logic             cyc_end;
  bss_req_e         cur_req;
  logic             cur_xmove;
  logic             ale_off;
  logic             psen_act;

  bss_phase_ctr #(.CYC_LEN(CYC_LEN)) u_ctr (
    .clk(clk), .rst_n(rst_n), .pos_o(pos), .cyc_end_o(cyc_end)
  );

  bss_cycle_latch u_latch (
    .clk(clk), .rst_n(rst_n), .req_i(bss_req_e'(req_i)), .xmove_i(xmove_i),
    .ale_off_we(ale_off_we), .ale_off_d(ale_off_d), .cyc_end_i(cyc_end),
    .cur_req_o(cur_req), .cur_xmove_o(cur_xmove), .ale_off_o(ale_off)
  );

  bss_strobe_gen #(.CYC_LEN(CYC_LEN), .CLKS_PER_STATE(CLKS_PER_STATE)) u_gen (
    .clk(clk), .rst_n(rst_n), .pos_i(pos), .cur_req_i(cur_req),
    .cur_xmove_i(cur_xmove), .ale_off_i(ale_off),
    .ale_o(ale_o), .psen_o(psen_act), .hi_sel_o(hi_sel_o)
  );

  generate
    if (PSEN_ACTIVE_LOW) begin : g_psen_low
      assign psen_n_o = !psen_act;
    end else begin : g_psen_high
      assign psen_n_o = psen_act;
    end
  endgenerate

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |-> (!psen_act && !hi_sel_o));

endmodule

// File: tb/bus_strobe_seq_tb.sv
module bus_strobe_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] req_i = 2'd0;
  logic       xmove_i = 1'b0;
  logic       ale_off_we = 1'b0;
  logic       ale_off_d = 1'b0;
  logic       ale_o, psen_n_o, hi_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .xmove_i(xmove_i),
    .ale_off_we(ale_off_we), .ale_off_d(ale_off_d),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .hi_sel_o(hi_sel_o)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  int unsigned e_req = 0;
  bit e_mv = 1'b0;
  bit e_off = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 psen_n", psen_n_o, 1'b1);
    chk("R8 hi_sel", hi_sel_o, 1'b0);
    rst_n = 1'b1;
    #1;
    for (int c = 0; c < 34; c++) begin
      for (int k = 0; k < 12; k++) begin
        bit xd, ale_e, psen_e, hi_e;
        xd     = (e_req >= 2);
        ale_e  = ((k % 6) < 2) && !(xd && k >= 6) && (!e_off || e_mv);
        psen_e = (e_req == 1) && ((k % 6) >= 3);
        hi_e   = (e_req == 1) || (e_req == 2);
        if (xd && k >= 6)        chk("R2 ale", ale_o, ale_e);
        else if (e_off && !e_mv) chk("R3 ale", ale_o, ale_e);
        else                     chk("R1 ale", ale_o, ale_e);
        if (xd) chk("R5 psen_n", psen_n_o, 1'b1);
        else    chk("R4 psen_n", psen_n_o, !psen_e);
        chk("R6 hi_sel", hi_sel_o, hi_e);
        chk("R9 exclusive", ale_o && !psen_n_o, 1'b0);
        if (k == 3) begin
          // R7: mid-cycle changes must not disturb the cycle in progress
          req_i   = ~req_i;
          xmove_i = ~xmove_i;
        end
        if (k == 11) begin
          int nx;
          nx = (c + 1) % 16;
          req_i      = 2'(nx % 4);
          xmove_i    = nx[2];
          ale_off_we = 1'b1;
          ale_off_d  = nx[3];
        end
        @(negedge clk);
        #1;
        if (k == 11) begin
          ale_off_we = 1'b0;
          ale_off_d  = 1'b0;
          e_req = unsigned'(int'(req_i));
          e_mv  = xmove_i;
          e_off = ((c + 1) % 16) >= 8;
        end
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule